// File: doc/BRIEF.md
# Sequential Code Lock Controller

This block is a small synchronous controller that unlocks after a fixed sequence of three 2-bit codes is entered. A code counts only on a clock edge where the qualifying strobe is high. Each correct code moves the controller one step closer to the unlocked state.

A wrong code leaves the progress already made in place, so the sequence does not restart. Once unlocked, the controller ignores all further entries until a synchronous reset returns it to the start. The current step is exported so that surrounding logic or a bench can follow progress.

The expected codes are parameters with fixed defaults: first 10, then 11, then 01. The design is one state register, a next-state decoder that holds by default and a one-line output decode.

Top module: `code_lock_fsm`

## Requirements
- R1: Reset is synchronous and active high. On a rising edge with `rst` high, `step_o` becomes 00 and `unlocked_o` becomes 0, even if a correct code is presented with `key_vld` high.
- R2: When `step_o` is 00 and `key_vld` is high with `key_in` = 10, `step_o` becomes 01 after the next rising edge.
- R3: When `step_o` is 01 and `key_vld` is high with `key_in` = 11, `step_o` becomes 10 after the next rising edge.
- R4: When `step_o` is 10 and `key_vld` is high with `key_in` = 01, `step_o` becomes 11 after the next rising edge.
- R5: When `key_vld` is low, `step_o` keeps its value across the edge, whatever `key_in` is.
- R6: A validated code that is not the one expected for the current step leaves `step_o` unchanged. In particular, it never returns the controller to 00.
- R7: `unlocked_o` is 1 exactly while `step_o` is 11 and 0 for the encodings 00, 01 and 10.
- R8: While `step_o` is 11, it stays 11 for every combination of `key_vld` and `key_in` until `rst` is applied.
- R9: Holding `key_vld` high with an unchanged code for several edges advances `step_o` by at most one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to step 00 |
| key_in | input | 2 | Code being entered |
| key_vld | input | 1 | Level qualifier; the code is evaluated on edges where this is high |
| step_o | output | 2 | Current step: 00 start, 01 and 10 intermediate, 11 unlocked |
| unlocked_o | output | 1 | High while the controller is in the unlocked step |

## Verification
The assertions check the following on every cycle:
- reset forces step 00;
- a low strobe leaves the step unchanged;
- the step only stays where it is or moves forward by one;
- the unlocked step is never left without reset;
- each rise of the unlock flag is preceded by the final correct code from step 10.

Only the bench scenarios can show the remaining behaviour. These are that each correct code advances the step at the right stage, that every wrong code at every stage is ignored, and that a held strobe advances just once. The bench covers this by reaching each of the four steps and applying all eight strobe and code combinations there.

// File: rtl/code_lock_fsm.sv
module code_lock_fsm #(
  parameter int          KEY_W = 2,
  parameter logic [KEY_W-1:0] KEY_A = 2'b10,
  parameter logic [KEY_W-1:0] KEY_B = 2'b11,
  parameter logic [KEY_W-1:0] KEY_C = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key_in,
  input  logic             key_vld,
  output logic [1:0]       step_o,
  output logic             unlocked_o
);

  localparam logic [1:0] S_IDLE = 2'b00;
  localparam logic [1:0] S_ONE  = 2'b01;
  localparam logic [1:0] S_TWO  = 2'b10;
  localparam logic [1:0] S_OPEN = 2'b11;

  logic [1:0] cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (key_vld) begin
      case (cur_q)
        S_IDLE:  if (key_in == KEY_A) nxt = S_ONE;
        S_ONE:   if (key_in == KEY_B) nxt = S_TWO;
        S_TWO:   if (key_in == KEY_C) nxt = S_OPEN;
        default: nxt = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= S_IDLE;
    else     cur_q <= nxt;
  end

  assign step_o     = cur_q;
  assign unlocked_o = (cur_q == S_OPEN);

endmodule

// File: rtl/code_lock_fsm_chk.sv
module code_lock_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] key_in,
  input logic       key_vld,
  input logic [1:0] step_o,
  input logic       unlocked_o
);

  // R1
  reset_to_idle_chk: assert property (@(posedge clk) rst |=> (step_o == 2'b00 && !unlocked_o));

  // R5
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !key_vld |=> $stable(step_o));

  // R6
  forward_only_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (step_o == $past(step_o) || step_o == $past(step_o) + 2'd1));

  // R8
  open_is_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    step_o == 2'b11 |=> step_o == 2'b11);

  // R7
  unlock_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_o) |-> ($past(step_o) == 2'b10 && $past(key_vld) && $past(key_in) == 2'b01));

endmodule

bind code_lock_fsm code_lock_fsm_chk u_chk (
  .clk(clk), .rst(rst), .key_in(key_in), .key_vld(key_vld),
  .step_o(step_o), .unlocked_o(unlocked_o)
);

// File: tb/code_lock_fsm_bench.sv
module code_lock_fsm_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] key_in = 2'b00;
  logic       key_vld = 1'b0;
  logic [1:0] step_o;
  logic       unlocked_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_lock_fsm u_code_lock_fsm (
    .clk(clk), .rst(rst), .key_in(key_in), .key_vld(key_vld),
    .step_o(step_o), .unlocked_o(unlocked_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [1:0] c);
    @(negedge clk);
    rst = r; key_vld = v; key_in = c;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] expect_next(input logic [1:0] s, input logic v, input logic [1:0] c);
    if (!v) return s;
    if (s == 2'b00 && c == 2'b10) return 2'b01;
    if (s == 2'b01 && c == 2'b11) return 2'b10;
    if (s == 2'b10 && c == 2'b01) return 2'b11;
    return s;
  endfunction

  task automatic go_to(input logic [1:0] target);
    step(1'b1, 1'b0, 2'b00);
    if (target >= 2'd1) step(1'b0, 1'b1, 2'b10);
    if (target >= 2'd2) step(1'b0, 1'b1, 2'b11);
    if (target >= 2'd3) step(1'b0, 1'b1, 2'b01);
  endtask

  task automatic t_reset;
    step(1'b1, 1'b0, 2'b00);
    check("R1 reset step", step_o, 0);
    check("R1 reset unlocked", unlocked_o, 0);
    step(1'b1, 1'b1, 2'b10);
    check("R1 reset priority", step_o, 0);
  endtask

  task automatic t_sequence;
    go_to(2'd0);
    step(1'b0, 1'b1, 2'b10);
    check("R2 first code", step_o, 1);
    check("R7 low at 01", unlocked_o, 0);
    step(1'b0, 1'b1, 2'b11);
    check("R3 second code", step_o, 2);
    check("R7 low at 10", unlocked_o, 0);
    step(1'b0, 1'b1, 2'b01);
    check("R4 third code", step_o, 3);
    check("R7 high at 11", unlocked_o, 1);
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 2; v++) begin
        for (int c = 0; c < 4; c++) begin
          logic [1:0] e;
          go_to(2'(s));
          e = expect_next(2'(s), v[0], 2'(c));
          step(1'b0, v[0], 2'(c));
          if (!v[0])                  check("R5 strobe low holds", step_o, e);
          else if (s == 3)            check("R8 open ignores input", step_o, e);
          else if (e == 2'(s))        check("R6 wrong code holds", step_o, e);
          else                        check("R2 R3 R4 advance", step_o, e);
          check("R7 flag matches step", unlocked_o, (e == 2'b11) ? 1 : 0);
        end
      end
    end
  endtask

  task automatic t_hold_open;
    go_to(2'd3);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, i[0], 2'(i));
      check("R8 stays open", step_o, 3);
    end
    step(1'b1, 1'b0, 2'b00);
    check("R1 reset leaves open", step_o, 0);
    check("R1 flag cleared", unlocked_o, 0);
  endtask

  task automatic t_repeat;
    go_to(2'd0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 2'b10);
    check("R9 held code single advance", step_o, 1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 2'b00);
    check("R6 wrong codes no restart", step_o, 1);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_sweep();
    t_hold_open();
    t_repeat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule